// File: doc/BRIEF.md
# Four-Lane Burst SPI Master with Slave Handshake

This block is an SPI master that moves 16-bit words four bits at a time. Four output lines and four input lines run in parallel, so each serial clock tick carries one nibble each way, full duplex. A word takes four ticks. When parity is enabled it takes five, and the fifth tick carries one even-parity bit per lane. Words are taken from a valid/ready input one at a time, and each received word appears on a one-cycle output strobe. After a single start pulse the block clocks a whole burst of `BURST_WORDS` words with no further control.

Chip select is active low and stays low for the whole burst. When the handshake option is on, the master holds the serial clock idle after lowering chip select and waits for the slave to pull its active-low enable line down. If the enable line is not seen low within a programmable number of system clocks, the master raises chip select for a short recovery window and then lowers it again for a fresh attempt. Four runtime settings shape the timing: a clock divider, a chip-select-to-first-clock delay, an inter-word gap and the handshake timeout. A received parity mismatch sets a sticky error flag and records the index of the first bad word. The flag is cleared by the next start.

Top module: `quad_spi_master`

## Requirements
- R1: Each word goes out most-significant nibble first; in every data tick, lane n of `sdo_o` carries bit n of the current nibble, so tick p carries word bits [15-4p:12-4p].
- R2: Input lanes are sampled on each rising `sclk_o` in the same order, and the assembled word is presented on `rx_data_o` with a one-cycle `rx_valid_o` pulse while chip select is still low.
- R3: With `cfg_par_en_i` low, every word takes exactly four `sclk_o` rising edges.
- R4: With `cfg_par_en_i` high, every word takes exactly five rising edges; in the fifth, lane n carries the XOR of word bits n, n+4, n+8 and n+12.
- R5: `sclk_o` idles low (mode 0); `sdo_o` never changes while `sclk_o` is high.
- R6: `cs_no` falls on start and rises exactly once, after the last word of the burst; `sclk_o` is low whenever `cs_no` is high.
- R7: With `cfg_hs_en_i` high, no `sclk_o` edge occurs until `ena_ni` has been seen low; with it low, `ena_ni` has no effect.
- R8: With handshake on and `ena_ni` held high, `cs_no` stays low for exactly `cfg_tmo_i`+1 system clocks, then high for 2 system clocks, then falls again for a new attempt.
- R9: At least `cfg_lead_i` system clocks separate the fall of `cs_no` and the first rising `sclk_o`. Between the last falling edge of one word and the first rising edge of the next, `sclk_o` stays low for at least `cfg_gap_i`+1 system clocks.
- R10: A burst accepts exactly `BURST_WORDS` words on `tx_valid_i`/`tx_ready_o`; `tx_ready_o` is high only while `cs_no` is low, and `busy_o` drops when the burst ends.
- R11: A parity mismatch on any input lane sets `par_err_o` and latches the burst index of the first failing word in `par_err_idx_o`; the flag stays set until the next accepted start, which clears it, and it never sets with parity disabled.
- R12: Within a word, each high and each low half-period of `sclk_o` lasts exactly `cfg_div_i`+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_par_en_i | input | 1 | Adds a parity tick to every word |
| cfg_hs_en_i | input | 1 | Waits for slave enable before clocking |
| cfg_div_i | input | DIV_W | Half-period of sclk minus one, in system clocks |
| cfg_lead_i | input | DLY_W | Minimum delay from chip select to first clock |
| cfg_gap_i | input | DLY_W | Idle gap between words |
| cfg_tmo_i | input | TMO_W | Handshake timeout minus one, in system clocks |
| start_i | input | 1 | Starts a burst when idle |
| busy_o | output | 1 | Burst in progress |
| tx_data_i | input | WORD_W | Word to send |
| tx_valid_i | input | 1 | Word to send is available |
| tx_ready_o | output | 1 | Master takes the word this cycle |
| rx_data_o | output | WORD_W | Received word |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| par_err_o | output | 1 | Sticky received-parity error |
| par_err_idx_o | output | IDX_W | Word index of first parity error |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| sdo_o | output | LANES | Output data lanes |
| sdi_i | input | LANES | Input data lanes |
| ena_ni | input | 1 | Slave ready, active low |

## Verification
The bench sweeps divider, parity and handshake settings and rebuilds every transmitted and received word from the lane samples taken at each clock rise. A nibble order or lane mapping error therefore shows up as scrambled words, and a missing or extra parity tick changes the rise count. A timeout run holds the enable line high, then measures the chip-select low and high widths: an off-by-one in the timeout counter, or a retry that does not re-raise chip select, moves those widths. Injected parity faults on chosen words check that the first bad index is latched and the flag survives later good words. The next start must clear it. Gap and lead settings are chosen large enough that a sequencer skipping either delay would clock the first rise visibly too early.

// File: rtl/qspi_pkg.sv
`timescale 1ns/1ps
package qspi_pkg;
  parameter int unsigned QS_WORD_W = 16;
  parameter int unsigned QS_LANES  = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HS_WAIT,
    SQ_RECOV,
    SQ_LEAD,
    SQ_LOAD,
    SQ_XFER,
    SQ_GAP
  } seq_state_e;
endpackage

// File: rtl/qspi_word_engine.sv
`timescale 1ns/1ps
module qspi_word_engine #(
  parameter int unsigned WORD_W = qspi_pkg::QS_WORD_W,
  parameter int unsigned LANES  = qspi_pkg::QS_LANES,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              go_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANES-1:0]  sdi_i,
  output logic              sclk_o,
  output logic [LANES-1:0]  sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_par_bad_o
);
  localparam int unsigned NIB    = WORD_W / LANES;
  localparam int unsigned TICK_W = $clog2(NIB + 1);

  logic              busy_q, sclk_q, done_q;
  logic [DIV_W-1:0]  div_cnt_q;
  logic [TICK_W-1:0] tick_q, last_tick;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q;
  logic [LANES-1:0]  tx_par_q, rx_par_q, sdo_q;
  logic [LANES-1:0]  tx_par_c, rx_calc_c;

  // per-lane even parity over the bits that lane carries in a word
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [NIB-1:0] tx_bits, rx_bits;
    for (genvar j = 0; j < NIB; j++) begin : g_bit
      assign tx_bits[j] = word_i[j*LANES+l];
      assign rx_bits[j] = rx_sh_q[j*LANES+l];
    end
    assign tx_par_c[l]  = ^tx_bits;
    assign rx_calc_c[l] = ^rx_bits;
  end

  assign last_tick = par_en_i ? TICK_W'(NIB) : TICK_W'(NIB - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      sclk_q    <= 1'b0;
      done_q    <= 1'b0;
      div_cnt_q <= '0;
      tick_q    <= '0;
      tx_sh_q   <= '0;
      rx_sh_q   <= '0;
      tx_par_q  <= '0;
      rx_par_q  <= '0;
      sdo_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !busy_q) begin
        busy_q    <= 1'b1;
        sclk_q    <= 1'b0;
        div_cnt_q <= div_i;
        tick_q    <= '0;
        sdo_q     <= word_i[WORD_W-1 -: LANES];
        tx_sh_q   <= word_i << LANES;
        tx_par_q  <= tx_par_c;
      end else if (busy_q) begin
        if (div_cnt_q != '0) begin
          div_cnt_q <= div_cnt_q - 1'b1;
        end else begin
          div_cnt_q <= div_i;
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            if (tick_q == TICK_W'(NIB)) rx_par_q <= sdi_i;
            else rx_sh_q <= {rx_sh_q[WORD_W-LANES-1:0], sdi_i};
          end else begin
            sclk_q <= 1'b0;
            if (tick_q == last_tick) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              tick_q  <= tick_q + 1'b1;
              sdo_q   <= (tick_q == TICK_W'(NIB - 1)) ? tx_par_q : tx_sh_q[WORD_W-1 -: LANES];
              tx_sh_q <= tx_sh_q << LANES;
            end
          end
        end
      end
    end
  end

  assign sclk_o       = sclk_q;
  assign sdo_o        = sdo_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign rx_word_o    = rx_sh_q;
  assign rx_par_bad_o = par_en_i && (|(rx_calc_c ^ rx_par_q));

  // R5
  sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> $stable(sdo_q));
  // R5
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sclk_q);
  // R4
  tick_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (tick_q <= last_tick));
endmodule

// File: rtl/qspi_burst_seq.sv
`timescale 1ns/1ps
module qspi_burst_seq
  import qspi_pkg::*;
#(
  parameter int unsigned BURST_WORDS = 64,
  parameter int unsigned DLY_W       = 8,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned RECOV_CYC   = 2,
  localparam int unsigned IDX_W      = $clog2(BURST_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             hs_en_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic [DLY_W-1:0] lead_i,
  input  logic [DLY_W-1:0] gap_i,
  input  logic             ena_ni,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic             go_o,
  input  logic             eng_busy_i,
  input  logic             eng_done_i,
  output logic             cs_no,
  output logic             busy_o,
  output logic [IDX_W-1:0] word_idx_o
);
  localparam int unsigned CNT_W = (TMO_W > DLY_W) ? TMO_W : DLY_W;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             cs_n_q;
  logic [1:0]       ena_sync_q;
  logic             ena_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ena_sync_q <= 2'b11;
    else         ena_sync_q <= {ena_sync_q[0], ena_ni};
  end
  assign ena_low = !ena_sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      cs_n_q  <= 1'b1;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_i) begin
          cs_n_q  <= 1'b0;
          cnt_q   <= '0;
          idx_q   <= '0;
          state_q <= hs_en_i ? SQ_HS_WAIT : SQ_LEAD;
        end
        SQ_HS_WAIT: begin
          if (ena_low) begin
            cnt_q   <= '0;
            state_q <= SQ_LEAD;
          end else if (cnt_q == CNT_W'(tmo_i)) begin
            cs_n_q  <= 1'b1;
            cnt_q   <= '0;
            state_q <= SQ_RECOV;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_RECOV: begin
          if (cnt_q == CNT_W'(RECOV_CYC - 1)) begin
            cs_n_q  <= 1'b0;
            cnt_q   <= '0;
            state_q <= SQ_HS_WAIT;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SQ_LEAD: begin
          if (cnt_q >= CNT_W'(lead_i)) state_q <= SQ_LOAD;
          else cnt_q <= cnt_q + 1'b1;
        end
        SQ_LOAD: if (tx_valid_i) state_q <= SQ_XFER;
        SQ_XFER: if (eng_done_i) begin
          if (idx_q == IDX_W'(BURST_WORDS - 1)) begin
            cs_n_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            cnt_q   <= '0;
            state_q <= SQ_GAP;
          end
        end
        SQ_GAP: begin
          if (cnt_q >= CNT_W'(gap_i)) state_q <= SQ_LOAD;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign tx_ready_o = (state_q == SQ_LOAD);
  assign go_o       = (state_q == SQ_LOAD) && tx_valid_i;
  assign cs_no      = cs_n_q;
  assign busy_o     = (state_q != SQ_IDLE);
  assign word_idx_o = idx_q;

  // R7
  hs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_HS_WAIT || state_q == SQ_RECOV) |-> !eng_busy_i);
  // R8
  recov_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RECOV) |-> cs_n_q);
  // R10
  ready_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !cs_n_q);
endmodule

// File: rtl/quad_spi_master.sv
`timescale 1ns/1ps
module quad_spi_master #(
  parameter int unsigned WORD_W      = qspi_pkg::QS_WORD_W,
  parameter int unsigned LANES       = qspi_pkg::QS_LANES,
  parameter int unsigned BURST_WORDS = 64,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned DLY_W       = 8,
  parameter int unsigned TMO_W       = 16,
  localparam int unsigned IDX_W      = $clog2(BURST_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_par_en_i,
  input  logic              cfg_hs_en_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [DLY_W-1:0]  cfg_lead_i,
  input  logic [DLY_W-1:0]  cfg_gap_i,
  input  logic [TMO_W-1:0]  cfg_tmo_i,
  input  logic              start_i,
  output logic              busy_o,
  input  logic [WORD_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              par_err_o,
  output logic [IDX_W-1:0]  par_err_idx_o,
  output logic              sclk_o,
  output logic              cs_no,
  output logic [LANES-1:0]  sdo_o,
  input  logic [LANES-1:0]  sdi_i,
  input  logic              ena_ni
);
  logic             go, eng_busy, eng_done, rx_bad;
  logic [IDX_W-1:0] word_idx;
  logic             err_q;
  logic [IDX_W-1:0] err_idx_q;

  qspi_burst_seq #(
    .BURST_WORDS(BURST_WORDS), .DLY_W(DLY_W), .TMO_W(TMO_W), .RECOV_CYC(2)
  ) seq_i (
    .clk_i, .rst_ni, .start_i,
    .hs_en_i(cfg_hs_en_i), .tmo_i(cfg_tmo_i), .lead_i(cfg_lead_i), .gap_i(cfg_gap_i),
    .ena_ni, .tx_valid_i, .tx_ready_o, .go_o(go),
    .eng_busy_i(eng_busy), .eng_done_i(eng_done),
    .cs_no, .busy_o, .word_idx_o(word_idx)
  );

  qspi_word_engine #(
    .WORD_W(WORD_W), .LANES(LANES), .DIV_W(DIV_W)
  ) eng_i (
    .clk_i, .rst_ni, .par_en_i(cfg_par_en_i), .div_i(cfg_div_i),
    .go_i(go), .word_i(tx_data_i), .sdi_i,
    .sclk_o, .sdo_o, .busy_o(eng_busy), .done_o(eng_done),
    .rx_word_o(rx_data_o), .rx_par_bad_o(rx_bad)
  );

  assign rx_valid_o = eng_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= 1'b0;
      err_idx_q <= '0;
    end else if (start_i && !busy_o) begin
      err_q     <= 1'b0;
      err_idx_q <= '0;
    end else if (eng_done && rx_bad && !err_q) begin
      err_q     <= 1'b1;
      err_idx_q <= word_idx;
    end
  end

  assign par_err_o     = err_q;
  assign par_err_idx_o = err_idx_q;

  // R6
  cs_idle_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);
  // R2
  rx_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !cs_no);
  // R11
  perr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !(start_i && !busy_o)) |=> par_err_o);
  // R11
  perr_idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o && !(start_i && !busy_o)) |=> $stable(par_err_idx_o));
endmodule

// File: tb/quad_spi_master_tb_top.sv
`timescale 1ns/1ps
module quad_spi_master_tb_top;
  localparam int BW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        par_en = 0, hs_en = 0, start = 0, tx_valid = 0, ena_n = 1;
  logic [3:0]  div = 0;
  logic [5:0]  lead = 0, gap = 0;
  logic [7:0]  tmo = 8'd50;
  logic        busy, tx_ready, rx_valid, par_err, sclk, cs_n;
  logic [15:0] tx_data, rx_data;
  logic [1:0]  perr_idx;
  logic [3:0]  sdo, sdi;

  quad_spi_master #(.BURST_WORDS(BW), .DIV_W(4), .DLY_W(6), .TMO_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_par_en_i(par_en), .cfg_hs_en_i(hs_en),
    .cfg_div_i(div), .cfg_lead_i(lead), .cfg_gap_i(gap), .cfg_tmo_i(tmo),
    .start_i(start), .busy_o(busy), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .par_err_o(par_err), .par_err_idx_o(perr_idx), .sclk_o(sclk), .cs_no(cs_n),
    .sdo_o(sdo), .sdi_i(sdi), .ena_ni(ena_n));

  int n_chk = 0, n_fail = 0;
  int seed = 1, bad_w = -1;
  logic [3:0] bad_mask = 0;

  function automatic logic [15:0] tw(int s, int w);
    return 16'((s * 7919 + w * 4099) ^ 16'hB2D5);
  endfunction
  function automatic logic [15:0] sw(int s, int w);
    return 16'((s * 2053 + w * 6007 + 311) ^ 16'h4C2A);
  endfunction
  function automatic logic [3:0] lpar(logic [15:0] v);
    logic [3:0] p;
    for (int n = 0; n < 4; n++) p[n] = v[n] ^ v[n+4] ^ v[n+8] ^ v[n+12];
    return p;
  endfunction

  // monitor state, sampled on falling clock edges
  int rises = 0, lo_cnt = 0, hi_cnt = 0, hw_err = 0, lo_err = 0;
  int gap_min = 1000, lead_meas = -1, rx_n = 0, acc = 0, cs_rises = 0;
  bit pend = 0, prev_sclk = 0, prev_cs = 1;
  logic [3:0]  cap [64];
  logic [15:0] rx_got [8];

  function automatic int tpw_f(logic p);
    return p ? 5 : 4;
  endfunction

  function automatic logic [3:0] slave_nib(int j, logic p, int s, int bw, logic [3:0] bm);
    int t = tpw_f(p);
    int w = j / t;
    int k = j % t;
    logic [15:0] v = sw(s, w);
    if (k < 4) return 4'((v >> (12 - 4 * k)) & 16'hF);
    return lpar(v) ^ ((w == bw) ? bm : 4'h0);
  endfunction

  always_comb sdi = slave_nib(rises, par_en, seed, bad_w, bad_mask);
  assign tx_data = tw(seed, acc);

  always @(negedge clk) begin
    if (start) begin
      rises = 0; hw_err = 0; lo_err = 0; gap_min = 1000; lead_meas = -1;
      rx_n = 0; acc = 0; pend = 0; cs_rises = 0; lo_cnt = 0; hi_cnt = 0;
    end else begin
      if (pend) acc++;
      pend = tx_valid && tx_ready;
      if (rx_valid) begin rx_got[rx_n % 8] = rx_data; rx_n++; end
      if (cs_n && !prev_cs) cs_rises++;
      if (sclk) begin
        if (!prev_sclk) begin
          if (rises == 0) lead_meas = lo_cnt;
          else if (rises % tpw_f(par_en) == 0) begin
            if (lo_cnt < gap_min) gap_min = lo_cnt;
          end else if (lo_cnt != int'(div) + 1) lo_err++;
          cap[rises % 64] = sdo;
          rises++;
        end
        hi_cnt++; lo_cnt = 0;
      end else begin
        if (prev_sclk) begin
          if (hi_cnt != int'(div) + 1) hw_err++;
          hi_cnt = 0;
        end
        if (!cs_n) lo_cnt++; else lo_cnt = 0;
      end
    end
    prev_sclk = sclk; prev_cs = cs_n;
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic pulse_start();
    step(); start = 1; step(); start = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_burst(int exp_err, int exp_idx);
    int t = tpw_f(par_en);
    for (int w = 0; w < BW; w++) begin
      logic [15:0] got = {cap[w*t], cap[w*t+1], cap[w*t+2], cap[w*t+3]};
      chk(got == tw(seed, w), "R1", "sent word", got, tw(seed, w));
      chk(rx_got[w] == sw(seed, w), "R2", "received word", rx_got[w], sw(seed, w));
      if (par_en) chk(cap[w*t+4] == lpar(tw(seed, w)), "R4", "parity tick", cap[w*t+4], lpar(tw(seed, w)));
    end
    if (par_en) chk(rises == BW * 5, "R4", "rises with parity", rises, BW * 5);
    else        chk(rises == BW * 4, "R3", "rises without parity", rises, BW * 4);
    chk(rx_n == BW, "R2", "rx strobes", rx_n, BW);
    chk(hw_err == 0 && lo_err == 0, "R12", "half-period errors", hw_err + lo_err, 0);
    chk(lead_meas >= int'(lead), "R9", "lead cycles", lead_meas, lead);
    chk(gap_min >= int'(gap) + 1, "R9", "gap cycles", gap_min, int'(gap) + 1);
    chk(cs_rises == 1 && cs_n, "R6", "cs rises", cs_rises, 1);
    chk(acc == BW && !busy, "R10", "accepted words", acc, BW);
    chk(par_err == exp_err[0], "R11", "parity flag", par_err, exp_err);
    if (exp_err != 0) chk(perr_idx == 2'(exp_idx), "R11", "error index", perr_idx, exp_idx);
  endtask

  task automatic run_burst(int d, bit p, bit hs, int ena_dly, int bw, logic [3:0] bm,
                           int exp_err, int exp_idx);
    seed++; div = 4'(d); par_en = p; hs_en = hs; bad_w = bw; bad_mask = bm;
    lead = 6'(6 + d); gap = 6'(7 + 2 * d); tmo = 8'd50;
    tx_valid = 1; ena_n = 1;
    pulse_start();
    if (hs) begin
      @(negedge clk);
      while (cs_n) @(negedge clk);
      repeat (ena_dly) @(negedge clk);
      chk(rises == 0, "R7", "clock before enable", rises, 0);
      ena_n = 0;
    end
    wait_idle();
    ena_n = 1; tx_valid = 0;
    check_burst(exp_err, exp_idx);
  endtask

  task automatic timeout_test();
    int n;
    seed++; div = 0; par_en = 0; hs_en = 1; bad_w = -1; bad_mask = 0;
    lead = 6'd6; gap = 6'd7; tmo = 8'd3; tx_valid = 1; ena_n = 1;
    pulse_start();
    @(negedge clk);
    while (cs_n) @(negedge clk);
    n = 0;
    while (!cs_n) begin n++; @(negedge clk); end
    chk(n == 4, "R8", "cs low width at timeout", n, 4);
    n = 0;
    while (cs_n) begin n++; @(negedge clk); end
    chk(n == 2, "R8", "cs recovery width", n, 2);
    chk(rises == 0, "R7", "clock during retries", rises, 0);
    ena_n = 0;
    wait_idle();
    ena_n = 1; tx_valid = 0;
    chk(rises == BW * 4, "R8", "burst after retry", rises, BW * 4);
    for (int w = 0; w < BW; w++)
      chk(rx_got[w] == sw(seed, w), "R8", "rx after retry", rx_got[w], sw(seed, w));
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !tx_ready && !par_err, "R6", "reset state",
        {cs_n, sclk, busy, tx_ready, par_err}, 5'b10000);
    for (int d = 0; d < 3; d++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++)
          run_burst(d, p[0], h[0], 12, -1, 4'h0, 0, 0);
    timeout_test();
    run_burst(1, 1'b1, 1'b0, 0, 2, 4'b0010, 1, 2);
    run_burst(0, 1'b1, 1'b1, 12, 1, 4'b1000, 1, 1);
    run_burst(0, 1'b1, 1'b0, 0, -1, 4'h0, 0, 0);
    run_burst(2, 1'b0, 1'b0, 0, 1, 4'b1111, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule